// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Acknowledge

This block is a row of identical interrupt interface cells that share a single processor interrupt level. Each cell stores an 8-bit vector number and keeps a pending flag that its peripheral sets. All pending flags are ORed into one request line towards the processor. When the processor answers with an acknowledge pulse, the pulse enters cell 0 and travels along the chain through the cells. The first cell on that path that has a pending request stops the pulse and supplies its own vector number. Cells further down never see that acknowledge.

The vector number tells the processor which handler to run, so software never has to poll the devices to find the requester. Priority comes only from position in the chain: a lower index means the cell sits closer to the processor. If an acknowledge reaches the far end of the chain and no cell has claimed it, the block reports a spurious acknowledge instead of a vector. Each cell's vector is written through a per-cell load strobe. The vector or the spurious flag appears one clock after the acknowledge cycle.

Top module: `irq_daisy_chain`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, all pending flags and stored vectors are zero, and irq_out, vec_valid, spurious and vec_out are all low.
- R2: A raise[i] bit sampled high at a clock edge sets the pending flag of cell i. irq_out is the OR of all pending flags and follows them in the cycle after that edge.
- R3: A vec_load[i] bit sampled high at a clock edge stores vec_wdata (8 bits) as the vector number of cell i. Other cells keep their vectors.
- R4: When iack is high at an edge and at least one cell is pending, the pending cell with the lowest index wins. In the following cycle vec_valid is 1 and vec_out holds that cell's vector.
- R5: A cell with no pending flag passes the acknowledge to the next cell in the same cycle. A single-cycle iack is therefore answered in the next cycle by a pending cell at any distance along the chain.
- R6: Only the winning cell's pending flag clears at the acknowledge edge. All other pending cells stay pending and win later acknowledges in index order.
- R7: When iack is high at an edge and no cell is pending, spurious is 1 and vec_valid is 0 in the next cycle. spurious is 0 in every other cycle.
- R8: vec_out is all zeros in any cycle where vec_valid is 0.
- R9: If raise[i] is high at the same edge where cell i wins an acknowledge, cell i stays pending.
- R10: If vec_load[i] is high at the same edge where cell i wins an acknowledge, vec_out carries the vector held before that edge. The new value is used from the next acknowledge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_load | input | NUM_CELLS | Per-cell vector write strobe |
| vec_wdata | input | VEC_W | Vector value to write |
| raise | input | NUM_CELLS | Per-cell request set pulse from each peripheral |
| iack | input | 1 | Acknowledge pulse from the processor, one acknowledge per high cycle |
| irq_out | output | 1 | Shared interrupt request, OR of all pending flags |
| vec_out | output | VEC_W | Vector number of the winning cell, zero otherwise |
| vec_valid | output | 1 | vec_out holds a claimed vector |
| spurious | output | 1 | The last acknowledge reached the end of the chain unclaimed |

## Verification
The hardest situations to reach are the ones where an acknowledge edge coincides with something else at the winning cell. These are a fresh raise on that cell, a vector write to it, or back-to-back acknowledges that drain several pending cells one per cycle. The stimulus builds these on purpose. It fills several cells and then issues iack on consecutive cycles until a spurious answer appears. It also lines raise and vec_load up with the cycle in which a known cell must win. A long run of random raise, load and acknowledge traffic then mixes these collisions with ordinary traffic. On every clock that run is compared against a behavioural model of the priority rule.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   // Kind of answer the chain gives to one acknowledge cycle
   typedef enum logic [1:0] {
      RSP_NONE     = 2'd0,
      RSP_VECTOR   = 2'd1,
      RSP_SPURIOUS = 2'd2
   } rsp_kind_t;

   localparam int unsigned VEC_W_MAX = 8;
endpackage

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VEC_W-1:0] wdata,
   input  logic             raise,
   input  logic             ack_in,
   output logic             ack_out,
   output logic             claim,
   output logic             pending,
   output logic [VEC_W-1:0] vec_drive
);
   logic [VEC_W-1:0] vec_q;
   logic             pend_q;

   // A pending cell absorbs the acknowledge; an idle one forwards it
   assign claim     = ack_in & pend_q;
   assign ack_out   = ack_in & ~pend_q;
   assign pending   = pend_q;
   assign vec_drive = claim ? vec_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (raise) begin
         pend_q <= 1'b1;
      end else if (claim) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
      end else if (load) begin
         vec_q <= wdata;
      end
   end
endmodule

// File: rtl/irq_chain_bus.sv
module irq_chain_bus
   import irq_chain_pkg::*;
#(
   parameter int unsigned NUM_CELLS = 4,
   parameter int unsigned VEC_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CELLS-1:0]       claim,
   input  logic [NUM_CELLS*VEC_W-1:0] drive,
   input  logic                       tail_ack,
   output logic [VEC_W-1:0]           vec_out,
   output logic                       vec_valid,
   output logic                       spurious
);
   logic [VEC_W-1:0] merged;
   rsp_kind_t        kind_d;
   rsp_kind_t        kind_q;
   logic [VEC_W-1:0] vec_q;

   // Wired-OR of the cell drivers; at most one is non-zero
   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM_CELLS; i++) begin
         merged = merged | drive[i*VEC_W +: VEC_W];
      end
   end

   always_comb begin
      if (|claim)        kind_d = RSP_VECTOR;
      else if (tail_ack) kind_d = RSP_SPURIOUS;
      else               kind_d = RSP_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= RSP_NONE;
         vec_q  <= '0;
      end else begin
         kind_q <= kind_d;
         vec_q  <= (kind_d == RSP_VECTOR) ? merged : '0;
      end
   end

   assign vec_out   = vec_q;
   assign vec_valid = (kind_q == RSP_VECTOR);
   assign spurious  = (kind_q == RSP_SPURIOUS);
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
   import irq_chain_pkg::*;
#(
   parameter int unsigned NUM_CELLS = 4,
   parameter int unsigned VEC_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CELLS-1:0] vec_load,
   input  logic [VEC_W-1:0]     vec_wdata,
   input  logic [NUM_CELLS-1:0] raise,
   input  logic                 iack,
   output logic                 irq_out,
   output logic [VEC_W-1:0]     vec_out,
   output logic                 vec_valid,
   output logic                 spurious
);
   localparam int unsigned DRV_W = NUM_CELLS * VEC_W;

   if (NUM_CELLS < 1) begin : g_bad_cells
      $error("irq_daisy_chain: NUM_CELLS must be at least 1");
   end
   if (VEC_W < 1 || VEC_W > VEC_W_MAX) begin : g_bad_width
      $error("irq_daisy_chain: VEC_W must lie in 1..8");
   end

   logic [NUM_CELLS:0]   ack_link;
   logic [NUM_CELLS-1:0] claim;
   logic [NUM_CELLS-1:0] pending;
   logic [DRV_W-1:0]     drive;

   assign ack_link[0] = iack;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      irq_chain_cell #(.VEC_W(VEC_W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (vec_load[i]),
         .wdata     (vec_wdata),
         .raise     (raise[i]),
         .ack_in    (ack_link[i]),
         .ack_out   (ack_link[i+1]),
         .claim     (claim[i]),
         .pending   (pending[i]),
         .vec_drive (drive[i*VEC_W +: VEC_W])
      );
   end

   assign irq_out = |pending;

   irq_chain_bus #(.NUM_CELLS(NUM_CELLS), .VEC_W(VEC_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim     (claim),
      .drive     (drive),
      .tail_ack  (ack_link[NUM_CELLS]),
      .vec_out   (vec_out),
      .vec_valid (vec_valid),
      .spurious  (spurious)
   );
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
   parameter int unsigned NUM_CELLS = 4,
   parameter int unsigned VEC_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CELLS-1:0] raise,
   input logic                 iack,
   input logic                 irq_out,
   input logic [VEC_W-1:0]     vec_out,
   input logic                 vec_valid,
   input logic                 spurious
);
   AST_ANSWER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_valid && spurious)); // R7

   AST_VECTOR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ($past(iack) && $past(irq_out))); // R4

   AST_SPURIOUS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      spurious |-> ($past(iack) && !$past(irq_out))); // R7

   AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      iack |=> (vec_valid || spurious)); // R5

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec_out == '0)); // R8

   AST_IRQ_NEEDS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(|raise)); // R2
endmodule

bind irq_daisy_chain irq_chain_checker #(.NUM_CELLS(NUM_CELLS), .VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .raise     (raise),
   .iack      (iack),
   .irq_out   (irq_out),
   .vec_out   (vec_out),
   .vec_valid (vec_valid),
   .spurious  (spurious)
);

// File: tb/test_irq_daisy_chain.sv
module test_irq_daisy_chain;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] drv_load = '0;
   logic [W-1:0] drv_wdata = '0;
   logic [N-1:0] drv_raise = '0;
   logic         drv_iack = 1'b0;
   logic         irq_out;
   logic [W-1:0] vec_out;
   logic         vec_valid;
   logic         spurious;

   int    n_checks = 0;
   int    n_fail = 0;
   string phase = "R1";

   // Behavioural reference state
   bit       m_pend [N];
   int       m_vec  [N];
   bit       e_valid;
   bit       e_spur;
   int       e_vec;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_daisy_chain #(.NUM_CELLS(N), .VEC_W(W)) i_irq_daisy_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .vec_load  (drv_load),
      .vec_wdata (drv_wdata),
      .raise     (drv_raise),
      .iack      (drv_iack),
      .irq_out   (irq_out),
      .vec_out   (vec_out),
      .vec_valid (vec_valid),
      .spurious  (spurious)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_pend[i]) begin m_pend[i] = 0; m_vec[i] = 0; end
         e_valid = 0; e_spur = 0; e_vec = 0;
      end else begin
         int  win;
         win = -1;
         if (drv_iack) begin
            for (int i = N-1; i >= 0; i--) if (m_pend[i]) win = i;
         end
         e_valid = (win >= 0);
         e_spur  = drv_iack && (win < 0);
         e_vec   = (win >= 0) ? m_vec[win] : 0;
         if (win >= 0) m_pend[win] = 0;
         for (int i = 0; i < N; i++) begin
            if (drv_raise[i]) m_pend[i] = 1;
            if (drv_load[i])  m_vec[i]  = drv_wdata;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      bit any;
      any = 0;
      foreach (m_pend[i]) any |= m_pend[i];
      check("R2 irq_out", int'(irq_out), int'(any));
      check("R4 vec_valid", int'(vec_valid), int'(e_valid));
      check("R8 vec_out", int'(vec_out), e_vec);
      check("R7 spurious", int'(spurious), int'(e_spur));
   end

   task automatic cyc(input logic [N-1:0] r, input logic a,
                      input logic [N-1:0] l, input logic [W-1:0] w);
      drv_raise = r; drv_iack = a; drv_load = l; drv_wdata = w;
      @(posedge clk); #1;
      drv_raise = '0; drv_iack = 1'b0; drv_load = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc('0, 1'b0, '0, '0);
   endtask

   initial begin
      phase = "R1";
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(2);

      phase = "R3";
      cyc('0, 0, 4'b0001, 8'h40);
      cyc('0, 0, 4'b0010, 8'h41);
      cyc('0, 0, 4'b0100, 8'h8A);
      cyc('0, 0, 4'b1000, 8'hFF);
      idle(1);

      phase = "R7";
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R5";           // far cell answers a single acknowledge
      cyc(4'b1000, 0, '0, '0);
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R4";
      cyc(4'b0100, 0, '0, '0);
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R6";           // drain in index order, back-to-back
      cyc(4'b1111, 0, '0, '0);
      for (int k = 0; k < N + 1; k++) cyc('0, 1, '0, '0);
      idle(2);
      cyc(4'b1010, 0, '0, '0);
      cyc('0, 1, '0, '0);
      idle(1);
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R9";           // raise meets its own claim
      cyc(4'b0001, 0, '0, '0);
      cyc(4'b0001, 1, '0, '0);
      idle(1);
      cyc('0, 1, '0, '0);
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R10";          // vector write meets its own claim
      cyc(4'b0010, 0, '0, '0);
      cyc('0, 1, 4'b0010, 8'h5C);
      cyc(4'b0010, 0, '0, '0);
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R1";           // reset mid-traffic clears everything
      cyc(4'b0110, 0, '0, '0);
      #2 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      cyc('0, 1, '0, '0);
      idle(2);

      phase = "R4";           // random mix
      for (int k = 0; k < 600; k++) begin
         cyc(N'($urandom_range(0, 15) & $urandom_range(0, 15)),
             1'($urandom_range(0, 2) == 0),
             N'($urandom_range(0, 7) == 0 ? $urandom_range(1, 15) : 0),
             W'($urandom_range(0, 255)));
      end
      idle(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule